// File: doc/BRIEF.md
# Commit Squash Resolver

This block keeps the squash state of each hardware thread at the commit end of an out-of-order pipeline. Each cycle it weighs three kinds of squash request for every thread. The first is a full squash raised when a trap's latency has run out. The second is a full squash raised from the thread context. The third is a partial squash from the execute stage, which carries a sequence number, an include-self flag, mispredict and branch-taken flags, a delay-slot flag and a redirect PC pair. From the request it picks it computes the squash boundary sent to the reorder buffer. It updates the thread's youngest valid sequence number and registers a backward broadcast for the earlier stages.

Each thread is in one of three states: running, waiting out a reorder-buffer squash, or holding a pending trap. The walk through the reorder buffer happens outside the block. Its completion comes back on a per-thread done input. New instructions for a thread are admitted only while the thread is running. The block also keeps the last committed PC pair of each thread, and a full squash redirects fetch to that pair.

Top module: `csr_resolver`

## Requirements
- R1: After reset every thread is Running (status code 0; 1 is ROB-squashing, 2 is trap-pending), its youngest sequence number is 0, and every broadcast output is 0.
- R2: A trap-completion request takes precedence over a thread-context request for the same thread. When both are raised in the same cycle, exactly one full squash is performed and bc_conflict_o pulses for one cycle.
- R3: An execute-stage squash is taken only when, after any full squash in the same cycle, the thread is not trap-pending and its sequence number is less than or equal to the thread's youngest valid sequence number (unsigned). Otherwise it has no effect on any output.
- R4: The broadcast done sequence number of an execute-stage squash is the request sequence number, minus one when include-self is set.
- R5: With delay slots enabled, the reorder-buffer squash point is the request sequence number plus one when mispredict is set and the slot-squash flag is clear, minus one when include-self is set.
- R6: After a taken execute-stage squash, the youngest valid sequence number equals the broadcast done sequence number.
- R7: A full squash uses a boundary of the ROB head sequence number minus one, or 0 when the ROB is empty. It sets the youngest sequence number to 0 and broadcasts the PC pair saved by the most recent commit strobe.
- R8: Every taken squash puts the thread in ROB-squashing. The thread asserts bc_robsq_o on every cycle until rob_done_i is sampled, and it then returns to Running.
- R9: A full squash clears the broadcast mispredict and taken flags. An execute-stage squash forwards them from its request.
- R10: alloc_ok_o is high only when the thread was Running at the start of the cycle and no squash is taken in that cycle. An admitted instruction's sequence number becomes the youngest, and a dropped one leaves the youngest unchanged.
- R11: A trap raise moves a Running thread to trap-pending. The thread stays there until a full squash arrives.
- R12: All broadcast outputs are registered. bc_squash_o is high for exactly the one cycle after a taken squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_done_i | input | NT | Per-thread trap-completion full squash request |
| ctx_flush_i | input | NT | Per-thread thread-context full squash request |
| trap_raise_i | input | NT | Per-thread trap raise: Running to trap-pending |
| ex_valid_i | input | NT | Per-thread execute-stage squash request |
| ex_seq_i | input | NT*SW | Execute squash sequence number |
| ex_incl_i | input | NT | Include the squashing instruction itself |
| ex_mispred_i | input | NT | Request is a branch mispredict |
| ex_taken_i | input | NT | Branch-taken flag to forward |
| ex_slot_sq_i | input | NT | Delay slot is squashed as well |
| ex_pc_i | input | NT*PW | Redirect PC |
| ex_npc_i | input | NT*PW | Redirect next PC |
| rob_empty_i | input | NT | Thread's ROB partition is empty |
| rob_head_seq_i | input | NT*SW | Sequence number at the ROB head |
| rob_done_i | input | NT | ROB reports its squash walk complete |
| alloc_valid_i | input | NT | New instruction offered for the thread |
| alloc_seq_i | input | NT*SW | Sequence number of the offered instruction |
| cmt_valid_i | input | NT | Commit strobe: save the PC pair |
| cmt_pc_i | input | NT*PW | Committed PC |
| cmt_npc_i | input | NT*PW | Committed next PC |
| alloc_ok_o | output | NT | Offered instruction admitted (combinational) |
| status_o | output | NT*2 | Thread status code |
| youngest_o | output | NT*SW | Youngest valid sequence number |
| bc_squash_o | output | NT | Squash broadcast pulse |
| bc_robsq_o | output | NT | ROB-squashing broadcast |
| bc_done_seq_o | output | NT*SW | Broadcast done sequence number |
| bc_rob_point_o | output | NT*SW | Broadcast ROB squash point |
| bc_mispred_o | output | NT | Broadcast mispredict flag |
| bc_taken_o | output | NT | Broadcast branch-taken flag |
| bc_pc_o | output | NT*PW | Broadcast redirect PC |
| bc_npc_o | output | NT*PW | Broadcast redirect next PC |
| bc_conflict_o | output | NT | Both full-squash kinds raised together |

## Verification
On every cycle the assertions check the relations between the internal squash events and the registered outputs. These cover the conflict pulse, rejection of execute squashes while a trap is pending, the youngest number after each squash kind, robsq being held until done, the flags cleared by a full squash, and admission being allowed only while Running. The exact boundary arithmetic can only be shown by the bench's scenarios and its per-cycle reference model. That arithmetic covers the include-self decrement, the delay-slot increment, the head-minus-one or zero choice, the unsigned age comparison, and the saved commit PC.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ROBSQ = 2'd1,
    ST_TRAP  = 2'd2
  } csr_state_e;
endpackage

// File: rtl/csr_pc_keep.sv
module csr_pc_keep #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_i,
  input  logic [PW-1:0] pc_i,
  input  logic [PW-1:0] npc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] npc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o  <= '0;
      npc_o <= '0;
    end else if (save_i) begin
      pc_o  <= pc_i;
      npc_o <= npc_i;
    end
  end
endmodule

// File: rtl/csr_thread.sv
module csr_thread
  import csr_pkg::*;
#(
  parameter int SW         = 12,
  parameter int PW         = 16,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_done_i,
  input  logic          ctx_flush_i,
  input  logic          trap_raise_i,
  input  logic          ex_valid_i,
  input  logic [SW-1:0] ex_seq_i,
  input  logic          ex_incl_i,
  input  logic          ex_mispred_i,
  input  logic          ex_taken_i,
  input  logic          ex_slot_sq_i,
  input  logic [PW-1:0] ex_pc_i,
  input  logic [PW-1:0] ex_npc_i,
  input  logic          rob_empty_i,
  input  logic [SW-1:0] rob_head_seq_i,
  input  logic          rob_done_i,
  input  logic          alloc_valid_i,
  input  logic [SW-1:0] alloc_seq_i,
  input  logic [PW-1:0] saved_pc_i,
  input  logic [PW-1:0] saved_npc_i,
  output logic          alloc_ok_o,
  output logic [1:0]    status_o,
  output logic [SW-1:0] youngest_o,
  output logic          bc_squash_o,
  output logic          bc_robsq_o,
  output logic [SW-1:0] bc_done_seq_o,
  output logic [SW-1:0] bc_rob_point_o,
  output logic          bc_mispred_o,
  output logic          bc_taken_o,
  output logic [PW-1:0] bc_pc_o,
  output logic [PW-1:0] bc_npc_o,
  output logic          bc_conflict_o,
  output logic          full_evt_o,
  output logic          ex_acc_evt_o
);
  // boundary for a squash that empties the whole thread
  function automatic logic [SW-1:0] full_boundary(logic empty, logic [SW-1:0] head);
    return empty ? '0 : head - SW'(1);
  endfunction

  function automatic logic [SW-1:0] ex_boundary(logic [SW-1:0] seq, logic incl);
    return seq - SW'(incl);
  endfunction

  // squash point when the delay slot may survive a mispredict
  function automatic logic [SW-1:0] slot_point(logic [SW-1:0] seq, logic incl,
                                               logic mis, logic slot_sq);
    return seq + SW'(mis & ~slot_sq) - SW'(incl);
  endfunction

  function automatic logic not_younger(logic [SW-1:0] seq, logic [SW-1:0] young);
    return seq <= young;
  endfunction

  csr_state_e    st_q, st_d, st_mid;
  logic [SW-1:0] young_q, young_d, young_mid;
  logic          sq_d, robsq_d, mis_d, tk_d, conf_d;
  logic [SW-1:0] done_d, point_d;
  logic [PW-1:0] pc_d, npc_d;
  logic          full_sq, ex_acc;
  logic [SW-1:0] full_bnd, ex_bnd, ex_point;

  assign full_sq  = trap_done_i | ctx_flush_i;
  assign full_bnd = full_boundary(rob_empty_i, rob_head_seq_i);
  assign ex_bnd   = ex_boundary(ex_seq_i, ex_incl_i);

  generate
    if (DELAY_SLOT) begin : g_slot
      assign ex_point = slot_point(ex_seq_i, ex_incl_i, ex_mispred_i, ex_slot_sq_i);
    end else begin : g_noslot
      logic unused_slot;
      assign unused_slot = ex_slot_sq_i;
      assign ex_point    = ex_bnd;
    end
  endgenerate

  // state after squash completion and any full squash
  always_comb begin
    st_mid    = st_q;
    young_mid = young_q;
    if (st_q == ST_ROBSQ && rob_done_i) st_mid = ST_RUN;
    if (full_sq) begin
      st_mid    = ST_ROBSQ;
      young_mid = '0;
    end
  end

  assign ex_acc = ex_valid_i && (st_mid != ST_TRAP) && not_younger(ex_seq_i, young_mid);
  assign alloc_ok_o = alloc_valid_i && (st_q == ST_RUN) && !full_sq && !ex_acc;
  assign full_evt_o   = full_sq;
  assign ex_acc_evt_o = ex_acc;

  always_comb begin
    st_d    = st_mid;
    young_d = young_mid;
    sq_d    = 1'b0;
    robsq_d = (st_q == ST_ROBSQ) && !rob_done_i;
    conf_d  = trap_done_i & ctx_flush_i;
    done_d  = bc_done_seq_o;
    point_d = bc_rob_point_o;
    mis_d   = bc_mispred_o;
    tk_d    = bc_taken_o;
    pc_d    = bc_pc_o;
    npc_d   = bc_npc_o;
    if (full_sq) begin
      sq_d    = 1'b1;
      robsq_d = 1'b1;
      done_d  = full_bnd;
      point_d = full_bnd;
      mis_d   = 1'b0;
      tk_d    = 1'b0;
      pc_d    = saved_pc_i;
      npc_d   = saved_npc_i;
    end
    if (ex_acc) begin
      st_d    = ST_ROBSQ;
      young_d = ex_bnd;
      sq_d    = 1'b1;
      robsq_d = 1'b1;
      done_d  = ex_bnd;
      point_d = ex_point;
      mis_d   = ex_mispred_i;
      tk_d    = ex_taken_i;
      pc_d    = ex_pc_i;
      npc_d   = ex_npc_i;
    end
    if (trap_raise_i && st_d == ST_RUN) st_d = ST_TRAP;
    if (alloc_ok_o) young_d = alloc_seq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_RUN;
      young_q        <= '0;
      bc_squash_o    <= 1'b0;
      bc_robsq_o     <= 1'b0;
      bc_done_seq_o  <= '0;
      bc_rob_point_o <= '0;
      bc_mispred_o   <= 1'b0;
      bc_taken_o     <= 1'b0;
      bc_pc_o        <= '0;
      bc_npc_o       <= '0;
      bc_conflict_o  <= 1'b0;
    end else begin
      st_q           <= st_d;
      young_q        <= young_d;
      bc_squash_o    <= sq_d;
      bc_robsq_o     <= robsq_d;
      bc_done_seq_o  <= done_d;
      bc_rob_point_o <= point_d;
      bc_mispred_o   <= mis_d;
      bc_taken_o     <= tk_d;
      bc_pc_o        <= pc_d;
      bc_npc_o       <= npc_d;
      bc_conflict_o  <= conf_d;
    end
  end

  assign status_o   = st_q;
  assign youngest_o = young_q;
endmodule

// File: rtl/csr_resolver.sv
module csr_resolver #(
  parameter int NT         = 2,
  parameter int SW         = 12,
  parameter int PW         = 16,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NT-1:0]          trap_done_i,
  input  logic [NT-1:0]          ctx_flush_i,
  input  logic [NT-1:0]          trap_raise_i,
  input  logic [NT-1:0]          ex_valid_i,
  input  logic [NT-1:0][SW-1:0]  ex_seq_i,
  input  logic [NT-1:0]          ex_incl_i,
  input  logic [NT-1:0]          ex_mispred_i,
  input  logic [NT-1:0]          ex_taken_i,
  input  logic [NT-1:0]          ex_slot_sq_i,
  input  logic [NT-1:0][PW-1:0]  ex_pc_i,
  input  logic [NT-1:0][PW-1:0]  ex_npc_i,
  input  logic [NT-1:0]          rob_empty_i,
  input  logic [NT-1:0][SW-1:0]  rob_head_seq_i,
  input  logic [NT-1:0]          rob_done_i,
  input  logic [NT-1:0]          alloc_valid_i,
  input  logic [NT-1:0][SW-1:0]  alloc_seq_i,
  input  logic [NT-1:0]          cmt_valid_i,
  input  logic [NT-1:0][PW-1:0]  cmt_pc_i,
  input  logic [NT-1:0][PW-1:0]  cmt_npc_i,
  output logic [NT-1:0]          alloc_ok_o,
  output logic [NT-1:0][1:0]     status_o,
  output logic [NT-1:0][SW-1:0]  youngest_o,
  output logic [NT-1:0]          bc_squash_o,
  output logic [NT-1:0]          bc_robsq_o,
  output logic [NT-1:0][SW-1:0]  bc_done_seq_o,
  output logic [NT-1:0][SW-1:0]  bc_rob_point_o,
  output logic [NT-1:0]          bc_mispred_o,
  output logic [NT-1:0]          bc_taken_o,
  output logic [NT-1:0][PW-1:0]  bc_pc_o,
  output logic [NT-1:0][PW-1:0]  bc_npc_o,
  output logic [NT-1:0]          bc_conflict_o
);
  // per-thread events brought out for the checker
  logic [NT-1:0] full_w;
  logic [NT-1:0] ex_acc_w;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [PW-1:0] spc, snpc;

    csr_pc_keep #(.PW(PW)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .save_i (cmt_valid_i[t]),
      .pc_i   (cmt_pc_i[t]),
      .npc_i  (cmt_npc_i[t]),
      .pc_o   (spc),
      .npc_o  (snpc)
    );

    csr_thread #(.SW(SW), .PW(PW), .DELAY_SLOT(DELAY_SLOT)) u_thr (
      .clk            (clk),
      .rst_n          (rst_n),
      .trap_done_i    (trap_done_i[t]),
      .ctx_flush_i    (ctx_flush_i[t]),
      .trap_raise_i   (trap_raise_i[t]),
      .ex_valid_i     (ex_valid_i[t]),
      .ex_seq_i       (ex_seq_i[t]),
      .ex_incl_i      (ex_incl_i[t]),
      .ex_mispred_i   (ex_mispred_i[t]),
      .ex_taken_i     (ex_taken_i[t]),
      .ex_slot_sq_i   (ex_slot_sq_i[t]),
      .ex_pc_i        (ex_pc_i[t]),
      .ex_npc_i       (ex_npc_i[t]),
      .rob_empty_i    (rob_empty_i[t]),
      .rob_head_seq_i (rob_head_seq_i[t]),
      .rob_done_i     (rob_done_i[t]),
      .alloc_valid_i  (alloc_valid_i[t]),
      .alloc_seq_i    (alloc_seq_i[t]),
      .saved_pc_i     (spc),
      .saved_npc_i    (snpc),
      .alloc_ok_o     (alloc_ok_o[t]),
      .status_o       (status_o[t]),
      .youngest_o     (youngest_o[t]),
      .bc_squash_o    (bc_squash_o[t]),
      .bc_robsq_o     (bc_robsq_o[t]),
      .bc_done_seq_o  (bc_done_seq_o[t]),
      .bc_rob_point_o (bc_rob_point_o[t]),
      .bc_mispred_o   (bc_mispred_o[t]),
      .bc_taken_o     (bc_taken_o[t]),
      .bc_pc_o        (bc_pc_o[t]),
      .bc_npc_o       (bc_npc_o[t]),
      .bc_conflict_o  (bc_conflict_o[t]),
      .full_evt_o     (full_w[t]),
      .ex_acc_evt_o   (ex_acc_w[t])
    );
  end
endmodule

// File: rtl/csr_resolver_chk.sv
module csr_resolver_chk #(
  parameter int NT = 2,
  parameter int SW = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NT-1:0]         trap_done_i,
  input logic [NT-1:0]         ctx_flush_i,
  input logic [NT-1:0]         ex_valid_i,
  input logic [NT-1:0]         rob_done_i,
  input logic [NT-1:0]         alloc_ok_o,
  input logic [NT-1:0][1:0]    status_o,
  input logic [NT-1:0][SW-1:0] youngest_o,
  input logic [NT-1:0]         bc_squash_o,
  input logic [NT-1:0]         bc_robsq_o,
  input logic [NT-1:0][SW-1:0] bc_done_seq_o,
  input logic [NT-1:0]         bc_mispred_o,
  input logic [NT-1:0]         bc_taken_o,
  input logic [NT-1:0]         bc_conflict_o,
  input logic [NT-1:0]         full_w,
  input logic [NT-1:0]         ex_acc_w
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    AST_CONFLICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_done_i[t] && ctx_flush_i[t]) |=> bc_conflict_o[t]); // R2

    AST_TRAP_BLOCKS_EX: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[t] == 2'd2 && ex_valid_i[t] && !full_w[t]) |-> !ex_acc_w[t]); // R3

    AST_EX_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
      ex_acc_w[t] |=> (youngest_o[t] == bc_done_seq_o[t])); // R6

    AST_FULL_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
      (full_w[t] && !ex_acc_w[t]) |=> (youngest_o[t] == '0)); // R7

    AST_SQUASH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      bc_squash_o[t] |-> (bc_robsq_o[t] && status_o[t] == 2'd1)); // R8

    AST_ROBSQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[t] == 2'd1 && !rob_done_i[t]) |=> (status_o[t] == 2'd1 && bc_robsq_o[t])); // R8

    AST_FULL_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (full_w[t] && !ex_acc_w[t]) |=> (!bc_mispred_o[t] && !bc_taken_o[t])); // R9

    AST_ADMIT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok_o[t] |-> (status_o[t] == 2'd0 && !full_w[t] && !ex_acc_w[t])); // R10

    AST_SQUASH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_w[t] && !ex_acc_w[t]) |=> !bc_squash_o[t]); // R12
  end
endmodule

bind csr_resolver csr_resolver_chk #(.NT(NT), .SW(SW)) u_chk (.*);

// File: tb/tb_csr_resolver.sv
`timescale 1ns/1ps
module tb_csr_resolver;
  localparam int NT = 2;
  localparam int SW = 12;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0] trap_done, ctx_flush, trap_raise, ex_valid, ex_incl, ex_mis, ex_tk, ex_slot;
  logic [NT-1:0][SW-1:0] ex_seq, rob_head, alloc_seq;
  logic [NT-1:0][PW-1:0] ex_pc, ex_npc, cmt_pc, cmt_npc;
  logic [NT-1:0] rob_empty, rob_done, alloc_v, cmt_v;
  logic [NT-1:0] alloc_ok, sq, robsq, mis, tk, conf;
  logic [NT-1:0][1:0] status;
  logic [NT-1:0][SW-1:0] young, done_seq, point;
  logic [NT-1:0][PW-1:0] bpc, bnpc;

  csr_resolver #(.NT(NT), .SW(SW), .PW(PW), .DELAY_SLOT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .trap_done_i(trap_done), .ctx_flush_i(ctx_flush), .trap_raise_i(trap_raise),
    .ex_valid_i(ex_valid), .ex_seq_i(ex_seq), .ex_incl_i(ex_incl),
    .ex_mispred_i(ex_mis), .ex_taken_i(ex_tk), .ex_slot_sq_i(ex_slot),
    .ex_pc_i(ex_pc), .ex_npc_i(ex_npc),
    .rob_empty_i(rob_empty), .rob_head_seq_i(rob_head), .rob_done_i(rob_done),
    .alloc_valid_i(alloc_v), .alloc_seq_i(alloc_seq),
    .cmt_valid_i(cmt_v), .cmt_pc_i(cmt_pc), .cmt_npc_i(cmt_npc),
    .alloc_ok_o(alloc_ok), .status_o(status), .youngest_o(young),
    .bc_squash_o(sq), .bc_robsq_o(robsq), .bc_done_seq_o(done_seq),
    .bc_rob_point_o(point), .bc_mispred_o(mis), .bc_taken_o(tk),
    .bc_pc_o(bpc), .bc_npc_o(bnpc), .bc_conflict_o(conf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  int            m_st[NT];
  logic [SW-1:0] m_young[NT], m_done[NT], m_point[NT];
  logic          m_sq[NT], m_robsq[NT], m_mis[NT], m_tk[NT], m_conf[NT];
  logic [PW-1:0] m_pc[NT], m_npc[NT], m_spc[NT], m_snpc[NT];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_st[t] = 0; m_young[t] = '0; m_done[t] = '0; m_point[t] = '0;
      m_sq[t] = 0; m_robsq[t] = 0; m_mis[t] = 0; m_tk[t] = 0; m_conf[t] = 0;
      m_pc[t] = '0; m_npc[t] = '0; m_spc[t] = '0; m_snpc[t] = '0;
    end
  endtask

  // does the model take the execute squash this cycle
  function automatic bit ex_taken_now(int t);
    int s = m_st[t];
    logic [SW-1:0] y = m_young[t];
    if (s == 1 && rob_done[t]) s = 0;
    if (trap_done[t] || ctx_flush[t]) begin s = 1; y = '0; end
    return ex_valid[t] && s != 2 && ex_seq[t] <= y;
  endfunction

  function automatic bit admit_now(int t);
    return alloc_v[t] && m_st[t] == 0 && !(trap_done[t] || ctx_flush[t]) && !ex_taken_now(t);
  endfunction

  task automatic model_step();
    if (!rst_n) begin model_reset(); return; end
    for (int t = 0; t < NT; t++) begin
      bit full = trap_done[t] || ctx_flush[t];
      bit take = ex_taken_now(t);
      bit adm  = admit_now(t);
      int s = m_st[t];
      m_conf[t] = trap_done[t] && ctx_flush[t];
      m_sq[t] = full || take;
      m_robsq[t] = (s == 1 && !rob_done[t]) || full || take;
      if (s == 1 && rob_done[t]) s = 0;
      if (full) begin
        s = 1; m_young[t] = '0;
        m_done[t] = rob_empty[t] ? '0 : rob_head[t] - 1;
        m_point[t] = m_done[t];
        m_mis[t] = 0; m_tk[t] = 0;
        m_pc[t] = m_spc[t]; m_npc[t] = m_snpc[t];
      end
      if (take) begin
        s = 1;
        m_done[t] = ex_incl[t] ? ex_seq[t] - 1 : ex_seq[t];
        m_point[t] = m_done[t] + ((ex_mis[t] && !ex_slot[t]) ? 1 : 0);
        m_young[t] = m_done[t];
        m_mis[t] = ex_mis[t]; m_tk[t] = ex_tk[t];
        m_pc[t] = ex_pc[t]; m_npc[t] = ex_npc[t];
      end
      if (trap_raise[t] && s == 0) s = 2;
      if (adm) m_young[t] = alloc_seq[t];
      m_st[t] = s;
      if (cmt_v[t]) begin m_spc[t] = cmt_pc[t]; m_snpc[t] = cmt_npc[t]; end
    end
  endtask

  task automatic compare_all();
    for (int t = 0; t < NT; t++) begin
      chk("R8", "status", 32'(status[t]), 32'(m_st[t]));
      chk("R6", "youngest", 32'(young[t]), 32'(m_young[t]));
      chk("R12", "squash", 32'(sq[t]), 32'(m_sq[t]));
      chk("R8", "robsq", 32'(robsq[t]), 32'(m_robsq[t]));
      chk("R4", "done_seq", 32'(done_seq[t]), 32'(m_done[t]));
      chk("R5", "rob_point", 32'(point[t]), 32'(m_point[t]));
      chk("R9", "mispred", 32'(mis[t]), 32'(m_mis[t]));
      chk("R9", "taken", 32'(tk[t]), 32'(m_tk[t]));
      chk("R7", "pc", 32'(bpc[t]), 32'(m_pc[t]));
      chk("R7", "npc", 32'(bnpc[t]), 32'(m_npc[t]));
      chk("R2", "conflict", 32'(conf[t]), 32'(m_conf[t]));
    end
  endtask

  // one clock: admission check on fresh inputs, then model step and compare
  task automatic step_cycle();
    #1;
    if (rst_n)
      for (int t = 0; t < NT; t++) chk("R10", "alloc_ok", 32'(alloc_ok[t]), 32'(admit_now(t)));
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic idle();
    trap_done = '0; ctx_flush = '0; trap_raise = '0; ex_valid = '0;
    ex_incl = '0; ex_mis = '0; ex_tk = '0; ex_slot = '0;
    rob_done = '0; alloc_v = '0; cmt_v = '0;
  endtask

  task automatic ex_req(int t, int seq, bit incl, bit mp, bit taken, bit slot, int pc);
    ex_valid[t] = 1; ex_seq[t] = SW'(seq); ex_incl[t] = incl; ex_mis[t] = mp;
    ex_tk[t] = taken; ex_slot[t] = slot; ex_pc[t] = PW'(pc); ex_npc[t] = PW'(pc + 4);
  endtask

  task automatic finish_squash(int t);
    rob_done[t] = 1; step_cycle(); idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    idle();
    ex_seq = '0; rob_head = '0; alloc_seq = '0; ex_pc = '0; ex_npc = '0;
    cmt_pc = '0; cmt_npc = '0; rob_empty = '0;
    repeat (3) step_cycle();
    rst_n = 1'b1;
    step_cycle();
    // R1 reset state
    chk("R1", "status0", 32'(status[0]), 0);
    chk("R1", "young0", 32'(young[0]), 0);
    chk("R1", "squash0", 32'(sq), 0);

    // fill thread 0, save commit PC, thread 1 allocation
    cmt_v[0] = 1; cmt_pc[0] = 16'h0100; cmt_npc[0] = 16'h0104;
    alloc_v = 2'b11; alloc_seq[0] = 5; alloc_seq[1] = 3;
    step_cycle(); idle();
    for (int s = 6; s <= 8; s++) begin
      alloc_v[0] = 1; alloc_seq[0] = SW'(s); step_cycle(); idle();
    end
    chk("R10", "youngest after admits", 32'(young[0]), 8);

    // mispredict with surviving delay slot
    ex_req(0, 6, 0, 1, 1, 0, 16'h0200);
    step_cycle(); idle();
    chk("R12", "squash pulse", 32'(sq[0]), 1);
    chk("R5", "point seq+1", 32'(point[0]), 7);
    chk("R6", "youngest=boundary", 32'(young[0]), 6);
    chk("R9", "mispred forwarded", 32'(mis[0]), 1);
    alloc_v[0] = 1; alloc_seq[0] = 9;
    step_cycle(); idle();
    chk("R8", "robsq held", 32'(robsq[0]), 1);
    chk("R10", "drop while squashing", 32'(young[0]), 6);
    chk("R12", "squash one cycle", 32'(sq[0]), 0);
    step_cycle();
    finish_squash(0);
    chk("R8", "back to running", 32'(status[0]), 0);
    chk("R8", "robsq released", 32'(robsq[0]), 0);

    // younger squash rejected; thread 1 squash in parallel
    ex_req(0, 7, 0, 0, 0, 0, 16'h0300);
    ex_req(1, 3, 1, 1, 0, 0, 16'h0400);
    step_cycle(); idle();
    chk("R3", "younger rejected", 32'(sq[0]), 0);
    chk("R3", "youngest kept", 32'(young[0]), 6);
    chk("R5", "t1 point", 32'(point[1]), 3);
    finish_squash(1);

    // include-self with slot squashed
    ex_req(0, 6, 1, 1, 0, 1, 16'h0500);
    step_cycle(); idle();
    chk("R4", "include-self done", 32'(done_seq[0]), 5);
    chk("R5", "slot squashed point", 32'(point[0]), 5);
    finish_squash(0);

    // include-self, slot survives
    ex_req(0, 5, 1, 1, 0, 0, 16'h0600);
    step_cycle(); idle();
    chk("R4", "include-self done 2", 32'(done_seq[0]), 4);
    chk("R5", "point with slot", 32'(point[0]), 5);
    finish_squash(0);

    // trap raise, blocked execute squash and allocation, then trap squash
    trap_raise[0] = 1; step_cycle(); idle();
    chk("R11", "trap pending", 32'(status[0]), 2);
    ex_req(0, 1, 0, 1, 1, 0, 16'h0700);
    alloc_v[0] = 1; alloc_seq[0] = 12;
    step_cycle(); idle();
    chk("R3", "trap blocks ex", 32'(sq[0]), 0);
    chk("R11", "still pending", 32'(status[0]), 2);
    chk("R10", "drop while trap", 32'(young[0]), 4);
    trap_done[0] = 1; rob_empty[0] = 0; rob_head[0] = 9;
    step_cycle(); idle();
    chk("R7", "head-1 boundary", 32'(done_seq[0]), 8);
    chk("R7", "youngest zero", 32'(young[0]), 0);
    chk("R7", "saved pc", 32'(bpc[0]), 32'h0100);
    chk("R9", "mispred cleared", 32'(mis[0]), 0);
    finish_squash(0);

    // context flush on empty ROB
    ctx_flush[0] = 1; rob_empty[0] = 1;
    step_cycle(); idle();
    chk("R7", "empty boundary", 32'(done_seq[0]), 0);
    chk("R7", "saved npc", 32'(bnpc[0]), 32'h0104);
    finish_squash(0);

    // both full requests together
    cmt_v[0] = 1; cmt_pc[0] = 16'h0800; cmt_npc[0] = 16'h0804;
    step_cycle(); idle();
    trap_done[0] = 1; ctx_flush[0] = 1; rob_empty[0] = 0; rob_head[0] = 3;
    step_cycle(); idle();
    chk("R2", "conflict flag", 32'(conf[0]), 1);
    chk("R2", "single squash", 32'(done_seq[0]), 2);
    chk("R7", "new saved pc", 32'(bpc[0]), 32'h0800);
    step_cycle();
    chk("R2", "conflict one cycle", 32'(conf[0]), 0);
    finish_squash(0);
    repeat (3) step_cycle();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule